// File: doc/BRIEF.md
# Hybrid Parallel-Prefix 16-Bit Adder

This block adds two 16-bit binary operands and a carry-in in pure combinational logic. It returns a 16-bit sum and a carry-out. Every carry comes from a parallel-prefix network rather than from a ripple chain. The result is valid in the same cycle as the operands, and the block holds no state.

The adder works in three steps. First, each bit position forms a generate signal (both operand bits set) and a propagate signal (exactly one operand bit set). The carry-in is folded into position 0 as an extra generate term. Second, the prefix network merges these per-bit pairs into the group generate for every span that starts at bit 0. That group generate is the carry into the next position.

The network has three parts:
- a sparse pairing level at the input;
- a dense log-depth core that runs over the odd positions only;
- a sparse fix-up level at the output that completes the even positions.

In total it has five combine levels and 32 generate cells. Each sum bit is the propagate of its position XORed with the carry into it.

Top module: `hybridPrefixAdder`

## Requirements
- R1: `sumOut` equals the low 16 bits of `opA + opB + carryIn`, with all three values taken as unsigned.
- R2: `carryOut` equals bit 16 of the 17-bit value `opA + opB + carryIn`.
- R3: When every bit position propagates (`opA` XOR `opB` is 0xFFFF), the carry-in passes through all 16 positions:
  - with `carryIn` = 0, `sumOut` = 0xFFFF and `carryOut` = 0;
  - with `carryIn` = 1, `sumOut` = 0x0000 and `carryOut` = 1.
- R4: A position where both operand bits are 1 sends a carry into the next position, whatever the lower bits are. At bit 15 this means `carryOut` = 1.
- R5: A position where both operand bits are 0 stops any carry from below. Bit 16 of the sum is then 0 when the killing position is bit 15.
- R6: The outputs depend only on the present inputs. Applying the same inputs again, after any other inputs, gives the same outputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First unsigned operand |
| opB | input | 16 | Second unsigned operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 16 | Low 16 bits of the sum |
| carryOut | output | 1 | Carry out of bit 15 |

## Verification
In one evaluation, the folded carry-in and a long propagate run can decide the same carry. With operands whose XOR is all ones, the carry-in must cross the whole prefix network. That path runs through the pairing level, all three dense levels and the even fix-up, and it is the longest span the graph builds.

The bench provokes this case in several ways:
- all-propagate operands with both carry-in values;
- a single generate at bit k with propagates above it, for every k;
- random vectors.

Each result is judged on every clock against a behavioural 17-bit sum of the same inputs.

// File: rtl/hybridAdderPkg.sv
package hybridAdderPkg;

  // Operand width; the hybrid graph assumes a power of two of at least 4.
  localparam int ADD_WIDTH = 16;

  // Group generate of a span made of a lower block followed by an upper block.
  function automatic logic combineGen(input logic genLo, input logic genHi, input logic propHi);
    return genHi | (genLo & propHi);
  endfunction

  // Group propagate of the same merged span.
  function automatic logic combineProp(input logic propLo, input logic propHi);
    return propLo & propHi;
  endfunction

endpackage

// File: rtl/adderPgGen.sv
module adderPgGen #(
  parameter int WIDTH = hybridAdderPkg::ADD_WIDTH
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] genBit,
  output logic [WIDTH-1:0] propBit
);

  logic [WIDTH-1:0] rawGen;

  assign rawGen  = opA & opB;
  assign propBit = opA ^ opB;

  // The carry-in becomes part of the generate term at position 0, so every
  // prefix span starting at 0 directly yields the carry out of its top bit.
  assign genBit[0] = rawGen[0] | (propBit[0] & carryIn);

  generate
    if (WIDTH > 1) begin : gUpper
      assign genBit[WIDTH-1:1] = rawGen[WIDTH-1:1];
    end
  endgenerate

endmodule

// File: rtl/adderPrefixNet.sv
module adderPrefixNet #(
  parameter int WIDTH = hybridAdderPkg::ADD_WIDTH
) (
  input  logic [WIDTH-1:0] genIn,
  input  logic [WIDTH-1:0] propIn,
  output logic [WIDTH-1:0] spanGen,   // generate of span [0,i] = carry into i+1
  output logic [WIDTH-1:0] spanProp   // propagate of span [0,i]
);
  import hybridAdderPkg::*;

  localparam int HALF      = WIDTH / 2;
  localparam int KS_LEVELS = $clog2(HALF);

  // Node arrays of the dense core, indexed by pair number (odd position 2j+1).
  logic [HALF-1:0] ksGen  [KS_LEVELS+1];
  logic [HALF-1:0] ksProp [KS_LEVELS+1];

  generate
    // Sparse input level: merge each even bit with the odd bit above it.
    for (genvar j = 0; j < HALF; j++) begin : gPair
      assign ksGen[0][j]  = combineGen(genIn[2*j], genIn[2*j+1], propIn[2*j+1]);
      assign ksProp[0][j] = combineProp(propIn[2*j], propIn[2*j+1]);
    end

    // Dense core: full-fanout prefix over the pairs, distances 1, 2, 4, ...
    for (genvar lvl = 1; lvl <= KS_LEVELS; lvl++) begin : gDense
      localparam int DIST = 1 << (lvl - 1);
      for (genvar j = 0; j < HALF; j++) begin : gNode
        if (j >= DIST) begin : gCell
          assign ksGen[lvl][j]  = combineGen(ksGen[lvl-1][j-DIST], ksGen[lvl-1][j],
                                             ksProp[lvl-1][j]);
          assign ksProp[lvl][j] = combineProp(ksProp[lvl-1][j-DIST], ksProp[lvl-1][j]);
        end else begin : gWire
          assign ksGen[lvl][j]  = ksGen[lvl-1][j];
          assign ksProp[lvl][j] = ksProp[lvl-1][j];
        end
      end
    end

    // Sparse output level: odd positions are complete; each even position
    // i > 0 merges span [0,i-1] with its own bit.
    for (genvar j = 0; j < HALF; j++) begin : gFinish
      assign spanGen[2*j+1]  = ksGen[KS_LEVELS][j];
      assign spanProp[2*j+1] = ksProp[KS_LEVELS][j];
      if (j == 0) begin : gBase
        assign spanGen[0]  = genIn[0];
        assign spanProp[0] = propIn[0];
      end else begin : gEven
        assign spanGen[2*j]  = combineGen(ksGen[KS_LEVELS][j-1], genIn[2*j], propIn[2*j]);
        assign spanProp[2*j] = combineProp(ksProp[KS_LEVELS][j-1], propIn[2*j]);
      end
    end
  endgenerate

endmodule

// File: rtl/adderSumGen.sv
module adderSumGen #(
  parameter int WIDTH = hybridAdderPkg::ADD_WIDTH
) (
  input  logic [WIDTH-1:0] propBit,
  input  logic [WIDTH:0]   carryVec,  // carryVec[i] = carry into position i
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  assign sumOut   = propBit ^ carryVec[WIDTH-1:0];
  assign carryOut = carryVec[WIDTH];

endmodule

// File: rtl/hybridPrefixAdder.sv
module hybridPrefixAdder #(
  parameter int WIDTH = hybridAdderPkg::ADD_WIDTH
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  logic [WIDTH-1:0] genBit;
  logic [WIDTH-1:0] propBit;
  logic [WIDTH-1:0] spanGen;
  logic [WIDTH-1:0] spanProp;
  logic [WIDTH:0]   carryVec;

  adderPgGen #(.WIDTH(WIDTH)) uPg (
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .genBit  (genBit),
    .propBit (propBit)
  );

  adderPrefixNet #(.WIDTH(WIDTH)) uPrefix (
    .genIn    (genBit),
    .propIn   (propBit),
    .spanGen  (spanGen),
    .spanProp (spanProp)
  );

  assign carryVec = {spanGen, carryIn};

  adderSumGen #(.WIDTH(WIDTH)) uSum (
    .propBit  (propBit),
    .carryVec (carryVec),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  // Carry-chain checks across the operand ports, the prefix network and the sum stage.
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      if (opA[i] & opB[i])
        AST_CARRY_GENERATE: assert (carryVec[i+1]);                 // R4
      if (!(opA[i] | opB[i]))
        AST_CARRY_KILL: assert (!carryVec[i+1]);                     // R5
      if (opA[i] ^ opB[i])
        AST_CARRY_PASS: assert (carryVec[i+1] == carryVec[i]);       // R3
      if (spanProp[i])
        AST_SPAN_PASS: assert (carryVec[i+1] == carryIn);            // R3
      AST_SUM_BIT: assert (sumOut[i] == (opA[i] ^ opB[i] ^ carryVec[i])); // R1
    end
  end

endmodule

// File: tb/hybridPrefixAdder_test.sv
module hybridPrefixAdder_test;

  localparam int W = 16;
  localparam int WATCHDOG_CYCLES = 20000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sumOut;
  logic         carryOut;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #2 clk = ~clk;  // 4 ns period

  hybridPrefixAdder uut (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  // Drive at a rising edge, then compare against a plain 17-bit sum at the next falling edge.
  task automatic applyCheck(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic c, input string tag);
    logic [W:0] expect17;
    @(posedge clk);
    opA     <= a;
    opB     <= b;
    carryIn <= c;
    @(negedge clk);
    expect17 = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    checkCount++;
    if (sumOut !== expect17[W-1:0] || carryOut !== expect17[W]) begin
      failCount++;
      $display("FAIL %s a=%h b=%h cin=%b: got sum=%h co=%b, expected sum=%h co=%b",
               tag, a, b, c, sumOut, carryOut, expect17[W-1:0], expect17[W]);
    end
  endtask

  task automatic expectFixed(input logic [W-1:0] s, input logic co, input string tag);
    checkCount++;
    if (sumOut !== s || carryOut !== co) begin
      failCount++;
      $display("FAIL %s: got sum=%h co=%b, expected sum=%h co=%b", tag, sumOut, carryOut, s, co);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN <= 1'b1;

    // Idle state: zero operands give zero result (R1, R2)
    applyCheck(16'h0000, 16'h0000, 1'b0, "R1 zero inputs");

    // All-propagate, carry-in crossing the full width (R3)
    applyCheck(16'hA5A5, 16'h5A5A, 1'b0, "R3 all-propagate cin0");
    expectFixed(16'hFFFF, 1'b0, "R3 all-propagate cin0 fixed");
    applyCheck(16'hA5A5, 16'h5A5A, 1'b1, "R3 all-propagate cin1");
    expectFixed(16'h0000, 1'b1, "R3 all-propagate cin1 fixed");
    applyCheck(16'hFFFF, 16'h0000, 1'b1, "R3 ffff plus cin");
    applyCheck(16'hFFFF, 16'h0001, 1'b0, "R2 ffff plus one");

    // Generate at the top bit (R4)
    applyCheck(16'h8000, 16'h8000, 1'b0, "R4 top generate");
    expectFixed(16'h0000, 1'b1, "R4 top generate fixed");
    applyCheck(16'hFFFF, 16'hFFFF, 1'b1, "R4 all generate cin1");

    // Kill at the top bit stops a carry from below (R5)
    applyCheck(16'h7FFF, 16'h0001, 1'b1, "R5 top kill");
    expectFixed(16'h8001, 1'b0, "R5 top kill fixed");
    applyCheck(16'h0000, 16'h0000, 1'b1, "R5 all kill cin1");

    // Single generate at bit k with propagates above it, for every k (R3, R4)
    for (int k = 0; k < W; k++) begin
      logic [W-1:0] lowMask;
      lowMask = (16'h1 << k) - 16'h1;
      applyCheck((16'hFFFF << k) & ~lowMask, (16'h1 << k) | (lowMask & 16'h5555), 1'b0,
                 "R4 generate ripple");
      applyCheck(~lowMask, lowMask, 1'b1, "R3 carry-in through propagate run");
    end

    // Random vectors (R1, R2)
    for (int n = 0; n < 2000; n++)
      applyCheck(W'($urandom), W'($urandom), 1'($urandom), "R1 random");

    // Same inputs again after other traffic give the same result (R6)
    applyCheck(16'h1234, 16'hEDCC, 1'b0, "R6 first apply");
    applyCheck(16'hFFFF, 16'hFFFF, 1'b0, "R6 intervening");
    applyCheck(16'h1234, 16'hEDCC, 1'b0, "R6 reapply");
    expectFixed(16'h0000, 1'b1, "R6 reapply fixed");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule